// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block turns a stream of dialled digits into loop-disconnect pulses on an active-low line output. A digit enters through a valid/ready handshake. In a pulse mode the block then breaks the loop once for each unit of the digit value, with a ten-break train for zero. A fixed make-state gap follows each digit. A mute output stays low for the whole sequence, so the speech path is silenced while the loop is broken.

A three-valued mode input chooses one of three behaviours: tone dialling, pulse dialling at 40:60 make/break, or pulse dialling at 33.3:66.7 make/break. A static rate input selects 10 or 20 pulses per second. A separate single-cycle strobe requests a timed flash: the loop is broken for one of four durations and then held made for a one-second recovery. Timing is counted in clock cycles. One half-millisecond lasts `TICK_CYCLES` clocks.

Back-pressure: `digit_ready` is high only while the block is idle and no flash is being requested in the same cycle. A digit transfers on a rising clock edge where `digit_valid` and `digit_ready` are both high. A source may hold `digit_valid` and `digit_code` steady through a busy period, and the digit is taken on the first idle cycle after it.

Top module: `pulse_dialer`

## Requirements
- R1: After reset, and while idle, `dp_n` and `mute_n` are high and `digit_ready` equals the inverse of `flash_req`.
- R2: A digit transfers only on an edge with `digit_valid` and `digit_ready` both high. A digit held valid through a busy period is taken on the first idle edge and dialled in full.
- R3: In a pulse mode, code d in 1..9 gives exactly d break periods and code 0 gives ten. Codes 10..15 are consumed with no effect on `dp_n` or `mute_n`.
- R4: With `mode_sel` = 2'b01 at 10 pps, each break lasts 60 ms and each make lasts 40 ms. The first break starts in the cycle after the transfer.
- R5: With `mode_sel` = 2'b10 at 10 pps, each break lasts 67 ms and each make lasts 33 ms.
- R6: With `fast_rate` = 1 (20 pps), the break, make and inter-digit times are half their 10 pps values: 30/20 ms, 33.5/16.5 ms and 400 ms.
- R7: After the last make of a digit, `dp_n` stays high and `mute_n` stays low for an inter-digit gap of 800 ms (at 10 pps). `digit_ready` returns high after the gap.
- R8: With `mode_sel` = 2'b00 or 2'b11 (tone), digits are consumed with no pulses and no mute, and `tone_ok` is high. In both pulse modes `tone_ok` is low.
- R9: A `flash_req` seen while idle drives `dp_n` low for 73, 100, 300 or 600 ms, chosen by `flash_sel` = 0, 1, 2 or 3, in any mode. A one-second period follows with `dp_n` high and `mute_n` low.
- R10: A flash request takes priority over a digit offered in the same cycle. A flash request made while busy is ignored.
- R11: `mute_n` is low from the first break or flash cycle to the end of the gap or recovery, and whenever `dp_n` is low.
- R12: The rate, mode and flash selection are sampled when a digit or flash is accepted. Changing them while busy does not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_rate | input | 1 | 1 selects 20 pps, 0 selects 10 pps |
| mode_sel | input | 2 | 00/11 tone, 01 pulse 40:60, 10 pulse 33.3:66.7 |
| flash_sel | input | 2 | Flash break 0:73, 1:100, 2:300, 3:600 ms |
| digit_valid | input | 1 | Digit offered |
| digit_code | input | 4 | Digit value 0..9, others discarded |
| digit_ready | output | 1 | Block can take a digit this cycle |
| flash_req | input | 1 | Flash request strobe |
| dp_n | output | 1 | Line pulse output, low = loop broken |
| mute_n | output | 1 | Low while a sequence is running |
| tone_ok | output | 1 | High when a tone generator may drive the line |

## Verification
The bound checker enforces rules that hold on every cycle. The loop is never broken without mute. `digit_ready` is never raised during a sequence or beside a flash request. An accepted pulse digit or idle flash breaks the loop on the next cycle, and a tone-mode digit leaves the line untouched. A counter also bounds every low stretch of `dp_n` by the longest flash. The exact widths of breaks, makes, gaps and recoveries are compared against the bench's queue model, cycle by cycle. So are the pulse count per digit, flash priority over a digit, and immunity to mid-sequence configuration changes. Only those scenarios can show them.

// File: rtl/pdial_pkg.sv
package pdial_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_MAK,
    ST_GAP,
    ST_FBRK,
    ST_FPAU
  } st_e;

  localparam logic [1:0] MODE_P40 = 2'b01;
  localparam logic [1:0] MODE_P33 = 2'b10;

  // longest phase in half-millisecond units (flash recovery)
  localparam int MAX_HALF_MS = 2000;

  function automatic logic is_pulse_mode(logic [1:0] m);
    return (m == MODE_P40) || (m == MODE_P33);
  endfunction

  function automatic int brk_half_ms(logic fast, logic r33);
    int t;
    t = r33 ? 134 : 120;
    return fast ? t / 2 : t;
  endfunction

  function automatic int mak_half_ms(logic fast, logic r33);
    int t;
    t = r33 ? 66 : 80;
    return fast ? t / 2 : t;
  endfunction

  function automatic int gap_half_ms(logic fast);
    return fast ? 800 : 1600;
  endfunction

  function automatic int flash_half_ms(logic [1:0] sel);
    case (sel)
      2'd0:    return 146;
      2'd1:    return 200;
      2'd2:    return 600;
      default: return 1200;
    endcase
  endfunction

  localparam int RECOVER_HALF_MS = 2000;

endpackage

// File: rtl/pdial_decode.sv
module pdial_decode (
  input  logic [3:0] code,
  output logic [3:0] count,
  output logic       dialable
);
  always_comb begin
    dialable = (code <= 4'd9);
    count    = (code == 4'd0) ? 4'd10 : code;
  end
endmodule

// File: rtl/pdial_timer.sv
module pdial_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val - W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pdial_fsm.sv
module pdial_fsm
  import pdial_pkg::*;
#(
  parameter int TICK_CYCLES = 25000,
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fast_rate,
  input  logic [1:0]   mode_sel,
  input  logic [1:0]   flash_sel,
  input  logic         digit_valid,
  input  logic [3:0]   dec_count,
  input  logic         dec_dialable,
  input  logic         flash_req,
  input  logic         tmr_done,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         digit_ready,
  output logic         dp_n,
  output logic         mute_n
);
  st_e        st_q, st_d;
  logic [3:0] left_q, left_d;
  logic       fast_q, fast_d;
  logic       r33_q, r33_d;

  function automatic logic [W-1:0] to_cyc(int half_ms);
    return W'(half_ms * TICK_CYCLES);
  endfunction

  always_comb begin
    st_d     = st_q;
    left_d   = left_q;
    fast_d   = fast_q;
    r33_d    = r33_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (flash_req) begin
          st_d     = ST_FBRK;
          tmr_load = 1'b1;
          tmr_val  = to_cyc(flash_half_ms(flash_sel));
        end else if (digit_valid && dec_dialable && is_pulse_mode(mode_sel)) begin
          st_d     = ST_BRK;
          left_d   = dec_count;
          fast_d   = fast_rate;
          r33_d    = (mode_sel == MODE_P33);
          tmr_load = 1'b1;
          tmr_val  = to_cyc(brk_half_ms(fast_rate, mode_sel == MODE_P33));
        end
      end
      ST_BRK: if (tmr_done) begin
        st_d     = ST_MAK;
        tmr_load = 1'b1;
        tmr_val  = to_cyc(mak_half_ms(fast_q, r33_q));
      end
      ST_MAK: if (tmr_done) begin
        tmr_load = 1'b1;
        if (left_q > 4'd1) begin
          st_d    = ST_BRK;
          left_d  = left_q - 4'd1;
          tmr_val = to_cyc(brk_half_ms(fast_q, r33_q));
        end else begin
          st_d    = ST_GAP;
          tmr_val = to_cyc(gap_half_ms(fast_q));
        end
      end
      ST_FBRK: if (tmr_done) begin
        st_d     = ST_FPAU;
        tmr_load = 1'b1;
        tmr_val  = to_cyc(RECOVER_HALF_MS);
      end
      ST_GAP, ST_FPAU: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      fast_q <= 1'b0;
      r33_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      fast_q <= fast_d;
      r33_q  <= r33_d;
    end
  end

  assign digit_ready = (st_q == ST_IDLE) && !flash_req;
  assign dp_n        = !((st_q == ST_BRK) || (st_q == ST_FBRK));
  assign mute_n      = (st_q == ST_IDLE);
endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
  import pdial_pkg::*;
#(
  parameter int TICK_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_rate,
  input  logic [1:0] mode_sel,
  input  logic [1:0] flash_sel,
  input  logic       digit_valid,
  input  logic [3:0] digit_code,
  output logic       digit_ready,
  input  logic       flash_req,
  output logic       dp_n,
  output logic       mute_n,
  output logic       tone_ok
);
  localparam int W = $clog2(MAX_HALF_MS * TICK_CYCLES + 1);

  logic [3:0]   dec_count;
  logic         dec_dialable;
  logic         tmr_load, tmr_done;
  logic [W-1:0] tmr_val;

  pdial_decode u_dec (
    .code     (digit_code),
    .count    (dec_count),
    .dialable (dec_dialable)
  );

  pdial_timer #(.W(W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  pdial_fsm #(.TICK_CYCLES(TICK_CYCLES), .W(W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .fast_rate    (fast_rate),
    .mode_sel     (mode_sel),
    .flash_sel    (flash_sel),
    .digit_valid  (digit_valid),
    .dec_count    (dec_count),
    .dec_dialable (dec_dialable),
    .flash_req    (flash_req),
    .tmr_done     (tmr_done),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .digit_ready  (digit_ready),
    .dp_n         (dp_n),
    .mute_n       (mute_n)
  );

  assign tone_ok = !is_pulse_mode(mode_sel);
endmodule

// File: rtl/pulse_dialer_chk.sv
module pulse_dialer_chk #(
  parameter int TICK_CYCLES = 25000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       digit_valid,
  input logic [3:0] digit_code,
  input logic       digit_ready,
  input logic       flash_req,
  input logic       dp_n,
  input logic       mute_n,
  input logic       tone_ok
);
  localparam int LONGEST_LOW = 1200 * TICK_CYCLES;

  int low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_run <= 0;
    else if (!dp_n) low_run <= low_run + 1;
    else            low_run <= 0;
  end

  assert_break_muted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_n |-> !mute_n);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    digit_ready |-> (mute_n && !flash_req));

  assert_flash_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req && mute_n) |=> (!dp_n && !mute_n));

  assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_valid && digit_ready && !tone_ok && digit_code <= 4'd9) |=> !dp_n);

  assert_tone_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_valid && digit_ready && tone_ok) |=> (dp_n && mute_n));

  assert_break_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LONGEST_LOW);
endmodule

bind pulse_dialer pulse_dialer_chk #(.TICK_CYCLES(TICK_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .digit_valid (digit_valid),
  .digit_code  (digit_code),
  .digit_ready (digit_ready),
  .flash_req   (flash_req),
  .dp_n        (dp_n),
  .mute_n      (mute_n),
  .tone_ok     (tone_ok)
);

// File: tb/pulse_dialer_bench.sv
`timescale 1ns/1ps
module pulse_dialer_bench;
  localparam int TK = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_rate = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic [1:0] flash_sel = 2'b00;
  logic       digit_valid = 1'b0;
  logic [3:0] digit_code = 4'd0;
  logic       flash_req = 1'b0;
  logic       digit_ready, dp_n, mute_n, tone_ok;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pulse_dialer #(.TICK_CYCLES(TK)) u_pulse_dialer (
    .clk(clk), .rst_n(rst_n), .fast_rate(fast_rate), .mode_sel(mode_sel),
    .flash_sel(flash_sel), .digit_valid(digit_valid), .digit_code(digit_code),
    .digit_ready(digit_ready), .flash_req(flash_req), .dp_n(dp_n),
    .mute_n(mute_n), .tone_ok(tone_ok)
  );

  // reference model: a queue of expected line segments (level, length in cycles)
  int q_lvl[$];
  int q_len[$];
  bit m_empty;

  function automatic bit pulse_mode(logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic push_seg(int lvl, int half_ms);
    q_lvl.push_back(lvl);
    q_len.push_back(half_ms * TK);
  endtask

  task automatic push_digit(logic [3:0] code, logic fast, logic [1:0] m);
    int n, period, brk;
    n = (code == 0) ? 10 : int'(code);
    period = fast ? 100 : 200;
    brk = period * ((m == 2'b10) ? 67 : 60) / 100;
    for (int i = 0; i < n; i++) begin
      push_seg(0, brk);
      push_seg(1, period - brk);
    end
    push_seg(1, fast ? 800 : 1600);
  endtask

  task automatic push_flash(logic [1:0] sel);
    int ms2;
    case (sel)
      2'd0: ms2 = 146;
      2'd1: ms2 = 200;
      2'd2: ms2 = 600;
      default: ms2 = 1200;
    endcase
    push_seg(0, ms2);
    push_seg(1, 2000);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_lvl.delete();
      q_len.delete();
    end else begin
      m_empty = (q_len.size() == 0);
      if (!m_empty) begin
        q_len[0] = q_len[0] - 1;
        if (q_len[0] == 0) begin
          void'(q_len.pop_front());
          void'(q_lvl.pop_front());
        end
      end else if (flash_req) begin
        push_flash(flash_sel);
      end else if (digit_valid && pulse_mode(mode_sel) && digit_code <= 4'd9) begin
        push_digit(digit_code, fast_rate, mode_sel);
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge, before stimulus moves
  always @(negedge clk) begin
    int e_dp, e_mute, e_rdy, e_tone;
    bit emp;
    emp    = (q_len.size() == 0);
    e_dp   = emp ? 1 : q_lvl[0];
    e_mute = emp ? 1 : 0;
    e_rdy  = (emp && !flash_req) ? 1 : 0;
    e_tone = pulse_mode(mode_sel) ? 0 : 1;
    chk("dp_n", int'(dp_n), e_dp);
    chk("mute_n", int'(mute_n), e_mute);
    chk("digit_ready", int'(digit_ready), e_rdy);
    chk("tone_ok", int'(tone_ok), e_tone);
  end

  task automatic wait_idle();
    @(negedge clk); #3;
    while (!mute_n) begin @(negedge clk); #3; end
    repeat (3) @(negedge clk);
  endtask

  task automatic send_digit(logic [3:0] code);
    @(negedge clk); #2;
    digit_valid = 1'b1;
    digit_code  = code;
    #1;
    while (!digit_ready) begin @(negedge clk); #3; end
    @(posedge clk);
    @(negedge clk); #2;
    digit_valid = 1'b0;
  endtask

  task automatic send_flash(logic [1:0] sel);
    @(negedge clk); #2;
    flash_sel = sel;
    flash_req = 1'b1;
    @(negedge clk); #2;
    flash_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog %s expired", cur_req);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R4"; mode_sel = 2'b01; fast_rate = 0;
    send_digit(4'd3); wait_idle();

    cur_req = "R3";
    send_digit(4'd0); wait_idle();
    send_digit(4'd12); repeat (20) @(negedge clk);

    cur_req = "R5"; #2 mode_sel = 2'b10;
    send_digit(4'd2); wait_idle();

    cur_req = "R6"; #2 fast_rate = 1; mode_sel = 2'b01;
    send_digit(4'd4); wait_idle();
    #2 mode_sel = 2'b10;
    send_digit(4'd1); wait_idle();

    cur_req = "R7"; #2 fast_rate = 0; mode_sel = 2'b01;
    send_digit(4'd1); wait_idle();

    cur_req = "R8"; #2 mode_sel = 2'b00;
    send_digit(4'd5); repeat (10) @(negedge clk);
    #2 mode_sel = 2'b11;
    send_digit(4'd7); repeat (10) @(negedge clk);

    cur_req = "R9"; #2 mode_sel = 2'b01;
    for (int s = 0; s < 4; s++) begin
      send_flash(2'(s)); wait_idle();
    end
    #2 mode_sel = 2'b00;
    send_flash(2'd1); wait_idle();

    cur_req = "R10"; #2 mode_sel = 2'b01;
    @(negedge clk); #2;
    flash_req = 1'b1; flash_sel = 2'd0; digit_valid = 1'b1; digit_code = 4'd2;
    @(negedge clk); #2 flash_req = 1'b0;
    cur_req = "R2";
    #1;
    while (!digit_ready) begin @(negedge clk); #3; end
    @(posedge clk); @(negedge clk); #2 digit_valid = 1'b0;
    cur_req = "R10";
    repeat (30) @(negedge clk);
    send_flash(2'd3); wait_idle();

    cur_req = "R12";
    send_digit(4'd2);
    repeat (50) @(negedge clk);
    #2 mode_sel = 2'b10; fast_rate = 1; flash_sel = 2'd2;
    cur_req = "R11";
    wait_idle();
    #2 mode_sel = 2'b01; fast_rate = 0;
    cur_req = "R12";
    send_flash(2'd0);
    repeat (40) @(negedge clk);
    #2 flash_sel = 2'd3;
    wait_idle();

    cur_req = "R2";
    send_digit(4'd1);
    send_digit(4'd2);
    wait_idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule